// File: doc/BRIEF.md
# Management-Bus Serial Register Slave

This block is the PHY-side end of the two-wire station management bus. The management clock arrives as an ordinary input and is oversampled by the system clock. The data line is split into an input, an output and an output enable. The block hunts for a run of at least thirty-two ones. It then decodes the start pattern, the opcode, a 5-bit device address and a 5-bit register address. When the device address matches its own, it carries out a 16-bit read or write on a simple register port.

Writes produce a one-clock strobe carrying the address and the assembled word. Reads take a word from the register port at the first turnaround bit. During that first bit the line stays released. The block then drives a zero for the second turnaround bit, followed by the sixteen data bits, most significant first. It never drives the line outside those eighteen bit times of a read addressed to it.

Both input lines pass through a two-flop synchroniser. A rising management-clock edge is acted on in the next system clock, so any output change comes a few system clocks after that edge and stays stable until the next one.

Top module: `mdio_slave`

## Requirements
- R1: After reset the output enable and the write strobe are low and the line is released.
- R2: A frame is only accepted after at least 32 consecutive one bits sampled on rising management-clock edges; a longer run is also accepted, a shorter one causes the frame to be ignored.
- R3: The start field must be a 0 then a 1; a zero after the preamble followed by another zero clears the preamble count and the frame is ignored.
- R4: The two opcode bits 1,0 mean read and 0,1 mean write; 0,0 and 1,1 cause the frame to be ignored.
- R5: The device address field (5 bits, MSB first, after the opcode) is compared with the phy_addr input; on a mismatch the line is never driven and no write occurs.
- R6: On an accepted write, reg_we is high for exactly one system clock after the sixteenth data bit is sampled, with reg_addr equal to the register field (5 bits, MSB first) and reg_wdata equal to the data sent MSB first.
- R7: On an accepted read, the line stays released during the first turnaround bit and is driven to 0 for the second.
- R8: On an accepted read, the word on reg_rdata for the addressed register is driven MSB first in the sixteen bit times after the turnaround, and the line is released after the last data bit.
- R9: Output changes only occur after a rising management-clock edge, so every driven bit is stable when the station samples it at the next rising edge.
- R10: The phy_addr input is used live, so changing it between frames changes which frames are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_addr | input | 5 | Device address this slave answers to |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| reg_addr | output | 5 | Register index of the current frame |
| reg_wdata | output | 16 | Write data, valid while reg_we is high |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 16 | Read data for reg_addr |

## Verification
On every cycle the assertions check four things: the write strobe is a single clock wide, the first driven bit of any read is a zero, the line is never driven while a write is committed, and the register index holds steady while the block drives. Preamble length, start-pattern and opcode rejection, address filtering, read data bit order and the exact bit time of release depend on whole frames. Only the bench's frame scenarios can show them, by comparing the line against a bit-by-bit expectation just before each rising management-clock edge.

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int PRE_LEN = 32,
  parameter int DW      = 16,
  parameter int AW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr,
  input  logic          mdc,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int HDR_LEN = 2 + 2 * AW;
  localparam int CW      = $clog2(PRE_LEN + DW + 1);

  typedef enum logic [2:0] {S_PRE, S_ST, S_HDR, S_TA, S_DAT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    mdc_q;
  logic [1:0]    mdi_q;
  logic [DW-1:0] sh;
  logic          is_rd;

  wire rise  = mdc_q[1] & ~mdc_q[2];
  wire bit_i = mdi_q[1];
  wire [HDR_LEN-1:0] hdr = {sh[HDR_LEN-2:0], bit_i};
  wire [1:0]    op  = hdr[HDR_LEN-1 -: 2];
  wire [AW-1:0] pa  = hdr[2*AW-1 -: AW];
  wire [AW-1:0] ra  = hdr[AW-1:0];
  wire hdr_ok = (op == 2'b10 || op == 2'b01) && pa == phy_addr;

  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q    <= '0;
      mdi_q    <= '1;
      st       <= S_PRE;
      cnt      <= '0;
      sh       <= '0;
      is_rd    <= 1'b0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
      reg_addr <= '0;
      reg_we   <= 1'b0;
    end else begin
      mdc_q  <= {mdc_q[1:0], mdc};
      mdi_q  <= {mdi_q[0], mdio_i};
      reg_we <= 1'b0;
      if (rise) begin
        case (st)
          S_PRE: begin
            if (!bit_i) begin
              cnt <= '0;
              if (cnt == CW'(PRE_LEN)) st <= S_ST;
            end else if (cnt != CW'(PRE_LEN)) begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ST: begin
            cnt <= '0;
            st  <= bit_i ? S_HDR : S_PRE;
          end
          S_HDR: begin
            sh <= {sh[DW-2:0], bit_i};
            if (cnt == CW'(HDR_LEN - 1)) begin
              cnt <= '0;
              if (hdr_ok) begin
                st       <= S_TA;
                reg_addr <= ra;
                is_rd    <= (op == 2'b10);
              end else begin
                st <= S_PRE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_TA: begin
            if (cnt == '0) begin
              cnt <= 1'b1;
              if (is_rd) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
                sh      <= reg_rdata;
              end
            end else begin
              cnt <= '0;
              st  <= S_DAT;
              if (is_rd) begin
                mdio_o <= sh[DW-1];
                sh     <= sh << 1;
              end
            end
          end
          S_DAT: begin
            if (is_rd) begin
              if (cnt == CW'(DW - 1)) mdio_oe <= 1'b0;
              else begin
                mdio_o <= sh[DW-1];
                sh     <= sh << 1;
              end
            end else begin
              sh <= {sh[DW-2:0], bit_i};
              if (cnt == CW'(DW - 1)) reg_we <= 1'b1;
            end
            if (cnt == CW'(DW - 1)) begin
              cnt <= '0;
              st  <= S_PRE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st  <= S_PRE;
            cnt <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mdio_o,
  input logic          mdio_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr
);
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_ta_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  p_no_drive_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !mdio_oe);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe)) |-> $stable(reg_addr));
endmodule

bind mdio_slave mdio_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/test_mdio_slave.sv
module test_mdio_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy = 5'h0B;
  logic        mdc = 1'b0;
  logic        st_oe = 1'b0, st_v = 1'b1;
  logic        mdio_o, mdio_oe, reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] rf [32];
  logic [15:0] model [32];
  int tests = 0, fails = 0, we_cnt = 0, exp_we = 0;
  logic prev_we = 1'b0;
  bit done = 0;

  wire mdio_i = mdio_oe ? mdio_o : (st_oe ? st_v : 1'b1);

  always #10 clk = ~clk;

  mdio_slave i_mdio_slave (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = rf[reg_addr];

  always @(posedge clk) begin
    if (reg_we) rf[reg_addr] <= reg_wdata;
    if (reg_we) we_cnt++;
    if (rst_n && reg_we && prev_we) begin
      fails++;
      $display("FAIL R6: strobe high two clocks, actual 2 expected 1");
    end
    prev_we <= reg_we;
  end

  task automatic chk(input bit ok, input string req, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic one_bit(input logic drv, input logic v, input logic eoe,
                         input logic eo, input string req);
    @(negedge clk);
    st_oe = drv; st_v = v; mdc = 1'b0;
    repeat (3) @(negedge clk);
    chk(mdio_oe == eoe && (!eoe || mdio_o == eo), req,
        $sformatf("line oe=%b o=%b expected oe=%b o=%b", mdio_oe, mdio_o, eoe, eo));
    mdc = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int pre, input logic [1:0] sf, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] d, input string req);
    bit acc = pre >= 32 && sf == 2'b01 && (op == 2'b10 || op == 2'b01) && pa == phy;
    bit rd  = acc && op == 2'b10;
    logic [15:0] rexp = model[ra];
    one_bit(1, 0, 0, 0, req);
    one_bit(1, 0, 0, 0, req);
    for (int i = 0; i < pre; i++) one_bit(1, 1, 0, 0, req);
    for (int i = 1; i >= 0; i--) one_bit(1, sf[i], 0, 0, req);
    for (int i = 1; i >= 0; i--) one_bit(1, op[i], 0, 0, req);
    for (int i = 4; i >= 0; i--) one_bit(1, pa[i], 0, 0, req);
    for (int i = 4; i >= 0; i--) one_bit(1, ra[i], 0, 0, req);
    if (op == 2'b10) begin
      one_bit(0, 1, 0, 0, rd ? "R7" : req);
      one_bit(0, 1, rd, 0, rd ? "R7" : req);
      for (int i = 15; i >= 0; i--) one_bit(0, 1, rd, rexp[i], rd ? "R8" : req);
    end else begin
      one_bit(1, 1, 0, 0, req);
      one_bit(1, 0, 0, 0, req);
      for (int i = 15; i >= 0; i--) one_bit(1, d[i], 0, 0, req);
    end
    one_bit(0, 1, 0, 0, rd ? "R8" : req);
    one_bit(0, 1, 0, 0, req);
    if (acc && op == 2'b01) begin
      model[ra] = d;
      exp_we++;
    end
    chk(we_cnt == exp_we, acc ? "R6" : req,
        $sformatf("write count %0d expected %0d", we_cnt, exp_we));
    chk(rf[ra] == model[ra], acc ? "R6" : req,
        $sformatf("reg %0d = %h expected %h", ra, rf[ra], model[ra]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not end, actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf[i] = 16'(i * 16'h0101) ^ 16'h5A00;
      model[i] = rf[i];
    end
    mdc = 1'b1;
    repeat (4) @(negedge clk);
    chk(mdio_oe == 1'b0 && reg_we == 1'b0, "R1",
        $sformatf("oe=%b we=%b expected 0 0", mdio_oe, reg_we));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdio_oe == 1'b0, "R1", $sformatf("oe=%b expected 0", mdio_oe));

    frame(32, 2'b01, 2'b01, 5'h0B, 5'd5,  16'hA5C3, "R6");
    frame(32, 2'b01, 2'b10, 5'h0B, 5'd5,  16'h0000, "R8");
    frame(32, 2'b01, 2'b10, 5'h0B, 5'd31, 16'h0000, "R9");
    frame(32, 2'b01, 2'b01, 5'h0B, 5'd31, 16'h8001, "R6");
    frame(32, 2'b01, 2'b10, 5'h0B, 5'd31, 16'h0000, "R7");
    frame(32, 2'b01, 2'b01, 5'h0C, 5'd7,  16'h1234, "R5");
    frame(32, 2'b01, 2'b10, 5'h1B, 5'd7,  16'h0000, "R5");
    frame(31, 2'b01, 2'b01, 5'h0B, 5'd9,  16'hFFFF, "R2");
    frame(31, 2'b01, 2'b10, 5'h0B, 5'd9,  16'h0000, "R2");
    frame(40, 2'b01, 2'b01, 5'h0B, 5'd9,  16'h7E81, "R2");
    frame(32, 2'b00, 2'b01, 5'h0B, 5'd10, 16'hBEEF, "R3");
    frame(32, 2'b01, 2'b11, 5'h0B, 5'd11, 16'hCAFE, "R4");
    frame(32, 2'b01, 2'b00, 5'h0B, 5'd11, 16'hCAFE, "R4");
    phy = 5'h1F;
    frame(32, 2'b01, 2'b01, 5'h0B, 5'd12, 16'h4321, "R10");
    frame(32, 2'b01, 2'b01, 5'h1F, 5'd12, 16'h4321, "R10");
    frame(32, 2'b01, 2'b10, 5'h1F, 5'd12, 16'h0000, "R10");
    frame(32, 2'b01, 2'b10, 5'h1F, 5'd0,  16'h0000, "R8");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule